// File: doc/BRIEF.md
# UART receiver with RTS handshake

This block receives asynchronous serial frames on an idle-high line and presents each completed word in a receive data register. A frame is one low start bit, seven, eight or nine data bits sent least significant bit first, an optional parity bit and one stop bit. The line is sampled once per `tick`, and `tick` is expected at sixteen times the bit rate. Each bit is taken at its midpoint. A start bit that has returned high by its midpoint is treated as noise and the receiver goes back to hunting.

Flow control uses the active-low `rts_n` output. It is low only while reception is enabled and the data register is empty. It goes high as soon as a word is stored there, and it falls again when software reads the low part of the register. If a frame finishes while the previous word is still unread, the new word is dropped and an overrun flag is raised. A parity error or a bad stop bit sets its own flag, but the word is still stored. When interrupts are enabled, every completed frame gives one one-cycle pulse. That pulse is either a receive-complete pulse or an error pulse, never both.

The frame state machine has the states IDLE, START, DATA, PAR and STOP, with these transitions:
- IDLE→START when a low sample is seen while reception is enabled.
- START→IDLE when the midpoint sample is high (glitch).
- START→DATA when the midpoint sample is low.
- DATA→PAR, or DATA→STOP if parity is off, after the last data bit.
- PAR→STOP after the parity bit.
- STOP→IDLE after the stop sample.
- Any state→IDLE when reception is disabled.

Top module: `uart_rx_rts`

## Requirements
- R1: After reset the data register reads 0, all three error flags are 0, no interrupt pulse is present, and `rts_n` is 1 while `rx_en` is 0.
- R2: While `rx_en` is 0, `rts_n` is 1 and frames on the line are not received. Within one cycle of `rx_en` becoming 1 with the register empty, `rts_n` is 0.
- R3: Frame layout: the line idles at 1, then a start bit of 0, then data LSB first, then the optional parity bit, then one stop bit. Each bit lasts 16 ticks. `len_sel` selects the data length: 2'b01 is 7 bits, 2'b10 is 9 bits, 2'b00 and 2'b11 are 8 bits. Stored bits above the selected length read 0.
- R4: `rdata_lo` carries word bits 7:0 and `rdata_hi` carries bit 8. A pulse on `rd_hi` alone does not consume the word and leaves `rts_n` unchanged.
- R5: `par_mode` selects the parity rule: 2'b01 is even, 2'b10 is odd, 2'b00 and 2'b11 mean no parity bit. A parity mismatch sets `par_flag`, the word is still stored, and `eri_pulse` fires instead of `rxi_pulse`.
- R6: A stop bit sampled as 0 sets `frm_flag`, the word is still stored, and `eri_pulse` fires instead of `rxi_pulse`.
- R7: If a frame completes while the register holds an unread word, `ovr_flag` is set, the register keeps the old word, and `eri_pulse` fires.
- R8: An error-free frame is stored and gives exactly one `rxi_pulse` of one cycle. At most one of `rxi_pulse` and `eri_pulse` is high in any cycle.
- R9: With `irq_en` at 0, neither pulse fires, but the data register and the flags still update.
- R10: `rts_n` is 1 from the cycle a word is stored until a `rd_lo` read, and it is 0 in the cycle after that read while `rx_en` is 1.
- R11: The error flags stay set until `err_clr` is pulsed. If a new error and `err_clr` arrive in the same cycle, the error wins.
- R12: A start bit that is high again at its midpoint (8 ticks after detection) is rejected. Nothing is stored, and the next valid frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 1 | Interrupt pulse enable |
| par_mode | input | 2 | 01 even, 10 odd, 00/11 no parity |
| len_sel | input | 2 | 01 seven bits, 10 nine bits, 00/11 eight bits |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| rd_lo | input | 1 | Read strobe of the low data part (consumes word) |
| rd_hi | input | 1 | Read strobe of the high data part (no effect) |
| err_clr | input | 1 | Clears all three error flags |
| rdata_lo | output | 8 | Stored word bits 7:0 |
| rdata_hi | output | 1 | Stored word bit 8 |
| ovr_flag | output | 1 | Overrun flag |
| par_flag | output | 1 | Parity error flag |
| frm_flag | output | 1 | Framing error flag |
| rxi_pulse | output | 1 | Receive-complete interrupt pulse |
| eri_pulse | output | 1 | Error interrupt pulse |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
The bench uses the default 16-tick oversampling and a two-stage line synchroniser, and holds `tick` high so that one bit lasts sixteen clocks. A full nine-bit frame with parity then takes about two hundred cycles. This makes it affordable to walk every length against every parity rule, to inject parity and stop errors, and to drive overrun, glitch and disabled-receiver cases with exact sample timing. Because the stop bit is sampled at its midpoint, a short low pulse after a framing error also exercises glitch rejection.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int WORD_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;
    localparam logic [1:0] LEN_7    = 2'b01;
    localparam logic [1:0] LEN_9    = 2'b10;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // line idles high, so reset the chain to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_s,
    input  logic              tick,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        par_mode,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output logic              par_bad,
    output logic              stop_bad
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int BW   = $clog2(WORD_W + 1);

    rx_state_t         state, nxt;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bit_i, nbits;
    logic [WORD_W-1:0] sreg;
    logic              par_on, par_odd, par_smp;
    logic              bit_end, mid_end, last_bit;

    always_comb begin
        unique case (len_sel)
            LEN_7:   nbits = BW'(7);
            LEN_9:   nbits = BW'(9);
            default: nbits = BW'(8);
        endcase
    end

    assign par_on   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign par_odd  = (par_mode == PAR_ODD);
    assign bit_end  = tick && (cnt == CW'(OVS - 1));
    assign mid_end  = tick && (cnt == CW'(HALF - 1));
    assign last_bit = (bit_i == nbits - 1'b1);
    assign word     = sreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tick && !rx_s) nxt = ST_START;
            ST_START: if (mid_end) nxt = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (bit_end && last_bit) nxt = par_on ? ST_PAR : ST_STOP;
            ST_PAR:   if (bit_end) nxt = ST_STOP;
            ST_STOP:  if (bit_end) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!enable) nxt = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_i    <= '0;
            sreg     <= '0;
            par_smp  <= 1'b0;
            done     <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cnt   <= '0;
                    bit_i <= '0;
                    if (nxt == ST_START) sreg <= '0;
                end
                ST_START: begin
                    if (tick) cnt <= mid_end ? '0 : cnt + 1'b1;
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt         <= '0;
                        sreg[bit_i] <= rx_s;
                        bit_i       <= bit_i + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        cnt     <= '0;
                        par_smp <= rx_s;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt      <= '0;
                        done     <= enable;
                        stop_bad <= ~rx_s;
                        par_bad  <= par_on & (par_smp ^ (^sreg) ^ par_odd);
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/urx_hold.sv
module urx_hold
    import urx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              irq_en,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              par_bad,
    input  logic              stop_bad,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              err_clr,
    output logic [WORD_W-1:0] data_q,
    output logic              ovr,
    output logic              per,
    output logic              fer,
    output logic              rxi,
    output logic              eri,
    output logic              rts_n
);
    logic full, hi_only, consume, room, bad;

    // a high-part read on its own never releases the word
    assign hi_only = rd_hi & ~rd_lo;
    assign consume = rd_lo & ~hi_only;
    assign room    = ~full | consume;
    assign bad     = par_bad | stop_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full   <= 1'b0;
            ovr    <= 1'b0;
            per    <= 1'b0;
            fer    <= 1'b0;
            rxi    <= 1'b0;
            eri    <= 1'b0;
        end else begin
            rxi <= 1'b0;
            eri <= 1'b0;
            if (err_clr) begin
                ovr <= 1'b0;
                per <= 1'b0;
                fer <= 1'b0;
            end
            if (done && !room) begin
                ovr <= 1'b1;
                eri <= irq_en;
            end else if (done) begin
                data_q <= word;
                full   <= 1'b1;
                if (par_bad)  per <= 1'b1;
                if (stop_bad) fer <= 1'b1;
                rxi <= irq_en & ~bad;
                eri <= irq_en & bad;
            end else if (consume) begin
                full <= 1'b0;
            end
        end
    end

    assign rts_n = ~rx_en | full;
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
    import urx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       rx_en,
    input  logic       irq_en,
    input  logic [1:0] par_mode,
    input  logic [1:0] len_sel,
    input  logic       tick,
    input  logic       rd_lo,
    input  logic       rd_hi,
    input  logic       err_clr,
    output logic [7:0] rdata_lo,
    output logic       rdata_hi,
    output logic       ovr_flag,
    output logic       par_flag,
    output logic       frm_flag,
    output logic       rxi_pulse,
    output logic       eri_pulse,
    output logic       rts_n
);
    logic              rx_s, done, par_bad, stop_bad;
    logic [WORD_W-1:0] word, data_q;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_s)
    );

    urx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_en),
        .rx_s     (rx_s),
        .tick     (tick),
        .len_sel  (len_sel),
        .par_mode (par_mode),
        .done     (done),
        .word     (word),
        .par_bad  (par_bad),
        .stop_bad (stop_bad)
    );

    urx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .irq_en   (irq_en),
        .done     (done),
        .word     (word),
        .par_bad  (par_bad),
        .stop_bad (stop_bad),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .err_clr  (err_clr),
        .data_q   (data_q),
        .ovr      (ovr_flag),
        .per      (par_flag),
        .fer      (frm_flag),
        .rxi      (rxi_pulse),
        .eri      (eri_pulse),
        .rts_n    (rts_n)
    );

    assign rdata_lo = data_q[7:0];
    assign rdata_hi = data_q[8];
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       irq_en,
    input logic       rd_lo,
    input logic       err_clr,
    input logic [7:0] rdata_lo,
    input logic       rdata_hi,
    input logic       ovr_flag,
    input logic       par_flag,
    input logic       frm_flag,
    input logic       rxi_pulse,
    input logic       eri_pulse,
    input logic       rts_n
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rxi_pulse, eri_pulse}));                                  // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> (!rxi_pulse && !eri_pulse));                            // R9
    AST_RXI_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        rxi_pulse |-> rts_n);                                               // R10
    AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_n && rx_en && !rd_lo) |=> rts_n);                              // R10
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ##1 !rxi_pulse);                                         // R2
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !err_clr) |=> ovr_flag);                               // R11
    AST_PER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_flag && !err_clr) |=> par_flag);                               // R11
    AST_FER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_flag && !err_clr) |=> frm_flag);                               // R11
    AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($stable(rdata_lo) && $stable(rdata_hi)));      // R7
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (.*);

// File: tb/uart_rx_rts_test.sv
module uart_rx_rts_test;
    logic       clk = 1'b0;
    logic       rst_n, rx_line, rx_en, irq_en, tick, rd_lo, rd_hi, err_clr;
    logic [1:0] par_mode, len_sel;
    logic [7:0] rdata_lo;
    logic       rdata_hi, ovr_flag, par_flag, frm_flag, rxi_pulse, eri_pulse, rts_n;
    int         total = 0;
    int         bad = 0;
    int         n_rxi = 0;
    int         n_eri = 0;
    bit         ended = 1'b0;

    always #2 clk = ~clk;

    uart_rx_rts uut (.*);

    always @(negedge clk) begin
        if (rxi_pulse) n_rxi++;
        if (eri_pulse) n_eri++;
    end

    // {len_sel, par_mode, bad parity, bad stop, data}
    localparam logic [14:0] VEC [10] = '{
        {2'd0, 2'd0, 1'b0, 1'b0, 9'h0A5},
        {2'd0, 2'd1, 1'b0, 1'b0, 9'h03C},
        {2'd0, 2'd2, 1'b0, 1'b0, 9'h081},
        {2'd1, 2'd0, 1'b0, 1'b0, 9'h1FF},
        {2'd2, 2'd1, 1'b0, 1'b0, 9'h1A5},
        {2'd2, 2'd2, 1'b0, 1'b0, 9'h0FF},
        {2'd0, 2'd1, 1'b1, 1'b0, 9'h055},
        {2'd3, 2'd0, 1'b0, 1'b1, 9'h012},
        {2'd1, 2'd2, 1'b1, 1'b1, 9'h02A},
        {2'd2, 2'd3, 1'b0, 1'b0, 9'h100}
    };

    function automatic int nbits(input logic [1:0] ls);
        return (ls == 2'd1) ? 7 : (ls == 2'd2) ? 9 : 8;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        if (which == 0) rd_lo = 1'b1;
        else if (which == 1) rd_hi = 1'b1;
        else err_clr = 1'b1;
        wait_clk(1);
        rd_lo = 1'b0; rd_hi = 1'b0; err_clr = 1'b0;
        wait_clk(1);
    endtask

    task automatic send(input logic [1:0] ls, input logic [1:0] pm, input logic [8:0] d,
                        input bit bp, input bit bs);
        int n;
        logic p;
        n = nbits(ls);
        len_sel = ls;
        par_mode = pm;
        rx_line = 1'b0;
        wait_clk(16);
        for (int i = 0; i < n; i++) begin
            rx_line = d[i];
            wait_clk(16);
        end
        if (pm == 2'd1 || pm == 2'd2) begin
            p = 1'b0;
            for (int i = 0; i < n; i++) p = p ^ d[i];
            rx_line = p ^ (pm == 2'd2) ^ bp;
            wait_clk(16);
        end
        if (bs) begin
            rx_line = 1'b0; wait_clk(12);
            rx_line = 1'b1; wait_clk(4);
        end else begin
            rx_line = 1'b1; wait_clk(16);
        end
        rx_line = 1'b1;
        wait_clk(12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rx_line = 1'b1; rx_en = 1'b0; irq_en = 1'b1; tick = 1'b1;
        rd_lo = 1'b0; rd_hi = 1'b0; err_clr = 1'b0; par_mode = 2'd0; len_sel = 2'd0;
        wait_clk(3);
        // R1 reset state
        check("R1 rts", rts_n, 1);
        check("R1 data", rdata_lo, 0);
        check("R1 flags", {ovr_flag, par_flag, frm_flag}, 0);
        rst_n = 1'b1;
        wait_clk(2);
        check("R1 pulses", {rxi_pulse, eri_pulse}, 0);

        // R2 disabled receiver ignores a frame
        send(2'd0, 2'd0, 9'h0C3, 1'b0, 1'b0);
        check("R2 no store", rdata_lo, 0);
        check("R2 no pulse", n_rxi, 0);
        check("R2 rts off", rts_n, 1);
        rx_en = 1'b1;
        wait_clk(1);
        check("R2 rts on", rts_n, 0);

        // table walk: R3 R4 R5 R6 R8 R10 R11
        for (int k = 0; k < 10; k++) begin
            logic [14:0] v;
            logic [8:0]  ed;
            int          r0, e0;
            bit          per_x, err_x;
            v = VEC[k];
            ed = v[8:0] & (9'h1FF >> (9 - nbits(v[14:13])));
            per_x = v[10] && (v[12:11] == 2'd1 || v[12:11] == 2'd2);
            err_x = per_x || v[9];
            r0 = n_rxi; e0 = n_eri;
            send(v[14:13], v[12:11], v[8:0], v[10], v[9]);
            check("R3 low data", rdata_lo, ed[7:0]);
            check("R4 high bit", rdata_hi, ed[8]);
            check("R5 parity flag", par_flag, per_x);
            check("R6 framing flag", frm_flag, v[9]);
            check("R8 rxi count", n_rxi - r0, !err_x);
            check("R5 R6 eri count", n_eri - e0, err_x);
            check("R10 rts high", rts_n, 1);
            strobe(1);
            check("R4 hi read ignored", rts_n, 1);
            strobe(0);
            check("R10 rts after read", rts_n, 0);
            check("R11 flag sticky", par_flag, per_x);
            strobe(2);
            check("R11 cleared", {ovr_flag, par_flag, frm_flag}, 0);
        end

        // R12 glitch start
        begin
            int r0;
            r0 = n_rxi;
            rx_line = 1'b0; wait_clk(4);
            rx_line = 1'b1; wait_clk(40);
            check("R12 no pulse", n_rxi, r0);
            check("R12 rts", rts_n, 0);
            send(2'd0, 2'd0, 9'h05A, 1'b0, 1'b0);
            check("R12 recovered", rdata_lo, 8'h5A);
            strobe(0);
        end

        // R7 overrun
        begin
            int r0, e0;
            send(2'd0, 2'd0, 9'h011, 1'b0, 1'b0);
            r0 = n_rxi; e0 = n_eri;
            send(2'd0, 2'd0, 9'h022, 1'b0, 1'b0);
            check("R7 flag", ovr_flag, 1);
            check("R7 old data kept", rdata_lo, 8'h11);
            check("R7 eri", n_eri - e0, 1);
            check("R7 no rxi", n_rxi - r0, 0);
            wait_clk(20);
            check("R11 ovr sticky", ovr_flag, 1);
            strobe(0);
            check("R10 rts after overrun read", rts_n, 0);
            strobe(2);
            check("R11 ovr cleared", ovr_flag, 0);
        end

        // R9 masked interrupts
        begin
            int r0, e0;
            irq_en = 1'b0;
            r0 = n_rxi; e0 = n_eri;
            send(2'd0, 2'd1, 9'h077, 1'b1, 1'b0);
            check("R9 flag still set", par_flag, 1);
            check("R9 data stored", rdata_lo, 8'h77);
            check("R9 no eri", n_eri - e0, 0);
            send(2'd0, 2'd0, 9'h033, 1'b0, 1'b0);
            check("R9 no pulses", (n_rxi - r0) + (n_eri - e0), 0);
            irq_en = 1'b1;
            strobe(0);
            strobe(2);
        end

        finish_run();
    end
endmodule